// File: doc/BRIEF.md
# SIMD Lane Processing Element with Nested Masking

One lane of a single-instruction multiple-data array. Every lane sees the same broadcast opcode, register index and data word. It runs them against its own register file, in which register 0 doubles as the accumulator. It also holds one shadow copy per register and a zero flag and a carry flag.

Conditional execution works through a masking depth counter rather than a single enable bit. A conditional mask instruction whose test passes pushes the lane one level deeper. While the depth is nonzero, the lane ignores ordinary work. Any further mask instruction deepens it unconditionally, so nested conditional regions unwind in matching order. An unmask instruction pops one level.

The lane reports whether it is masked, so the array can reduce this across lanes. It also raises a registered store request, with the selected register's value, for conditional store instructions. A mode input can block stores from masked lanes.

Top module: `simd_lane_pe`

## Requirements
- R1: After reset all registers, shadows and both flags are zero, the depth is 0, and frozen_o and store_en_o are low.
- R2: ADD (code 1) and SUB (code 2) write ACC with ACC+reg or ACC-reg modulo 2^W. Z is set when the result is zero. C is the carry out for ADD and the borrow (ACC < reg) for SUB.
- R3: AND (3), OR (4), XOR (5), INV (6, ACC gets NOT reg) and MOVA (7, ACC gets reg) update ACC and Z. They leave C unchanged.
- R4: SHL (8) shifts ACC left by one and puts the old MSB into C. SHR (9) shifts ACC right by one and puts the old LSB into C. Both set Z from the result.
- R5: RST (10) clears the selected register and clears Z. SET (11) loads it with all ones and leaves the flags alone.
- R6: MOVR (12) copies ACC to the selected register. SWAP (13) exchanges the register with its shadow. MOVTS (14) copies the register to its shadow. MOVFS (15) copies the shadow back. LOAD (29) writes data_i to the register. None of these touch the flags.
- R7: SETZ (16), SETC (17), CLRZ (18) and CLRC (19) force the named flag to 1 or 0 and leave the other flag alone.
- R8: At depth 0, FRZC (20), FRZNC (21), FRZZ (22) and FRZNZ (23) raise the depth to 1 only when C=1, C=0, Z=1 or Z=0 respectively. Otherwise the depth stays 0.
- R9: At nonzero depth, every code other than 20 to 28 leaves registers, shadows and flags unchanged. Codes 20 to 23 then add one level whatever the flags hold.
- R10: UNFRZ (24) lowers a nonzero depth by one and leaves a zero depth at zero. frozen_o is high exactly while the depth is nonzero.
- R11: The depth saturates at LVL_MAX (256 by default). Further mask instructions at that depth leave it there.
- R12: STC (25), STNC (26), STZ (27) and STNZ (28) raise store_en_o in the cycle after issue only when C=1, C=0, Z=1 or Z=0 respectively. store_data_o then shows the selected register.
- R13: With frz_store_block_i high, a masked lane raises no store request. With it low, a masked lane's store follows R12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Broadcast instruction valid this cycle |
| op_i | input | 5 | Operation code |
| sel_i | input | SEL_W | Register index |
| data_i | input | W | Broadcast data word |
| frz_store_block_i | input | 1 | Block stores from masked lanes |
| frozen_o | output | 1 | Lane is masked (depth nonzero) |
| level_o | output | LVL_W | Current masking depth |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| acc_o | output | W | Accumulator (register 0) |
| store_en_o | output | 1 | Registered store request |
| store_data_o | output | W | Register value captured by the last store instruction |

## Verification
The assertions assume that an issued op_i is one of the listed codes, and that sel_i is below the register count whenever issue_i is high. The stimulus uses only enumerated codes and register indices 0 to 6 of the default eight, and drives instructions one at a time with idle cycles between them. The depth properties assume the counter only moves through issued mask or unmask codes. The bench drives the depth to saturation and back down purely through those codes.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

  typedef enum logic [4:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_SUB   = 5'd2,
    OP_AND   = 5'd3,
    OP_OR    = 5'd4,
    OP_XOR   = 5'd5,
    OP_INV   = 5'd6,
    OP_MOVA  = 5'd7,
    OP_SHL   = 5'd8,
    OP_SHR   = 5'd9,
    OP_RST   = 5'd10,
    OP_SET   = 5'd11,
    OP_MOVR  = 5'd12,
    OP_SWAP  = 5'd13,
    OP_MOVTS = 5'd14,
    OP_MOVFS = 5'd15,
    OP_SETZ  = 5'd16,
    OP_SETC  = 5'd17,
    OP_CLRZ  = 5'd18,
    OP_CLRC  = 5'd19,
    OP_FRZC  = 5'd20,
    OP_FRZNC = 5'd21,
    OP_FRZZ  = 5'd22,
    OP_FRZNZ = 5'd23,
    OP_UNFRZ = 5'd24,
    OP_STC   = 5'd25,
    OP_STNC  = 5'd26,
    OP_STZ   = 5'd27,
    OP_STNZ  = 5'd28,
    OP_LOAD  = 5'd29
  } pe_op_e;

  function automatic logic is_frz_grp(pe_op_e op);
    return (op >= OP_FRZC) && (op <= OP_UNFRZ);
  endfunction

  function automatic logic is_store(pe_op_e op);
    return (op >= OP_STC) && (op <= OP_STNZ);
  endfunction

  // flag test shared by masking and stores: 0:C=1 1:C=0 2:Z=1 3:Z=0
  function automatic logic flag_test(logic [1:0] kind, logic z, logic c);
    case (kind)
      2'd0:    return c;
      2'd1:    return !c;
      2'd2:    return z;
      default: return !z;
    endcase
  endfunction

endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_lane_pkg::*;
#(
  parameter int W = 16
) (
  input  pe_op_e         op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   rs_i,
  input  logic [W-1:0]   shd_i,
  input  logic [W-1:0]   data_i,
  output logic           wr_en_o,
  output logic           wr_acc_o,
  output logic [W-1:0]   wr_data_o,
  output logic           shw_en_o,
  output logic [W-1:0]   shw_data_o,
  output logic           z_we_o,
  output logic           z_d_o,
  output logic           c_we_o,
  output logic           c_d_o
);

  logic [W:0] sum_w;
  logic [W:0] dif_w;

  assign sum_w = {1'b0, acc_i} + {1'b0, rs_i};
  assign dif_w = {1'b0, acc_i} - {1'b0, rs_i};

  always_comb begin
    wr_en_o    = 1'b0;
    wr_acc_o   = 1'b1;
    wr_data_o  = '0;
    shw_en_o   = 1'b0;
    shw_data_o = rs_i;
    z_we_o     = 1'b0;
    z_d_o      = 1'b0;
    c_we_o     = 1'b0;
    c_d_o      = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        wr_en_o = 1'b1; wr_data_o = sum_w[W-1:0];
        c_we_o  = 1'b1; c_d_o = sum_w[W];
        z_we_o  = 1'b1;
      end
      OP_SUB: begin
        wr_en_o = 1'b1; wr_data_o = dif_w[W-1:0];
        c_we_o  = 1'b1; c_d_o = dif_w[W];
        z_we_o  = 1'b1;
      end
      OP_AND:  begin wr_en_o = 1'b1; wr_data_o = acc_i & rs_i; z_we_o = 1'b1; end
      OP_OR:   begin wr_en_o = 1'b1; wr_data_o = acc_i | rs_i; z_we_o = 1'b1; end
      OP_XOR:  begin wr_en_o = 1'b1; wr_data_o = acc_i ^ rs_i; z_we_o = 1'b1; end
      OP_INV:  begin wr_en_o = 1'b1; wr_data_o = ~rs_i;        z_we_o = 1'b1; end
      OP_MOVA: begin wr_en_o = 1'b1; wr_data_o = rs_i;         z_we_o = 1'b1; end
      OP_SHL: begin
        wr_en_o = 1'b1; wr_data_o = {acc_i[W-2:0], 1'b0};
        c_we_o  = 1'b1; c_d_o = acc_i[W-1];
        z_we_o  = 1'b1;
      end
      OP_SHR: begin
        wr_en_o = 1'b1; wr_data_o = {1'b0, acc_i[W-1:1]};
        c_we_o  = 1'b1; c_d_o = acc_i[0];
        z_we_o  = 1'b1;
      end
      OP_RST: begin
        wr_en_o = 1'b1; wr_acc_o = 1'b0; wr_data_o = '0;
        z_we_o  = 1'b1;
      end
      OP_SET:  begin wr_en_o = 1'b1; wr_acc_o = 1'b0; wr_data_o = '1; end
      OP_MOVR: begin wr_en_o = 1'b1; wr_acc_o = 1'b0; wr_data_o = acc_i; end
      OP_LOAD: begin wr_en_o = 1'b1; wr_acc_o = 1'b0; wr_data_o = data_i; end
      OP_SWAP: begin
        wr_en_o  = 1'b1; wr_acc_o = 1'b0; wr_data_o = shd_i;
        shw_en_o = 1'b1;
      end
      OP_MOVTS: shw_en_o = 1'b1;
      OP_MOVFS: begin wr_en_o = 1'b1; wr_acc_o = 1'b0; wr_data_o = shd_i; end
      OP_SETZ: begin z_we_o = 1'b1; z_d_o = 1'b1; end
      OP_CLRZ: begin z_we_o = 1'b1; z_d_o = 1'b0; end
      OP_SETC: begin c_we_o = 1'b1; c_d_o = 1'b1; end
      OP_CLRC: begin c_we_o = 1'b1; c_d_o = 1'b0; end
      default: ;
    endcase
    // zero test for writes into the accumulator; RST forces Z low
    if (z_we_o && wr_en_o && wr_acc_o) z_d_o = (wr_data_o == '0);
  end

endmodule

// File: rtl/simd_lane_regfile.sv
module simd_lane_regfile #(
  parameter int W     = 16,
  parameter int NREG  = 8,
  parameter int SEL_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             shw_en_i,
  input  logic [W-1:0]     shw_data_i,
  output logic [W-1:0]     acc_o,
  output logic [W-1:0]     rs_o,
  output logic [W-1:0]     shd_o
);

  logic [W-1:0] reg_q [NREG];
  logic [W-1:0] shd_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_q[i] <= '0;
        shd_q[i] <= '0;
      end else begin
        if (wr_en_i && (wr_idx_i == SEL_W'(i))) reg_q[i] <= wr_data_i;
        if (shw_en_i && (sel_i == SEL_W'(i)))   shd_q[i] <= shw_data_i;
      end
    end
  end

  assign acc_o = reg_q[0];
  assign rs_o  = reg_q[sel_i];
  assign shd_o = shd_q[sel_i];

endmodule

// File: rtl/simd_lane_mask.sv
module simd_lane_mask #(
  parameter int LVL_MAX = 256,
  parameter int LVL_W   = $clog2(LVL_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frz_req_i,
  input  logic             frz_cond_i,
  input  logic             unfrz_req_i,
  output logic [LVL_W-1:0] level_o,
  output logic             frozen_o
);

  localparam logic [LVL_W-1:0] LvlTop = LVL_W'(LVL_MAX);

  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
    end else if (frz_req_i) begin
      // nested regions deepen unconditionally
      if ((frozen_o || frz_cond_i) && level_q != LvlTop) level_q <= level_q + 1'b1;
    end else if (unfrz_req_i && level_q != '0) begin
      level_q <= level_q - 1'b1;
    end
  end

  assign level_o  = level_q;
  assign frozen_o = (level_q != '0);

  p_unfrz_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unfrz_req_i && !frz_req_i && level_q != '0) |=> (level_q == $past(level_q) - 1'b1));

  p_unfrz_floor_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unfrz_req_i && !frz_req_i && level_q == '0) |=> (level_q == '0));

  p_sat_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_req_i && level_q == LvlTop) |=> (level_q == LvlTop));

  p_nest_inc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_req_i && frozen_o && level_q != LvlTop) |=> (level_q == $past(level_q) + 1'b1));

endmodule

// File: rtl/simd_lane_pe.sv
module simd_lane_pe
  import simd_lane_pkg::*;
#(
  parameter int W       = 16,
  parameter int NREG    = 8,
  parameter int SEL_W   = $clog2(NREG),
  parameter int LVL_MAX = 256,
  parameter int LVL_W   = $clog2(LVL_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [4:0]       op_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [W-1:0]     data_i,
  input  logic             frz_store_block_i,
  output logic             frozen_o,
  output logic [LVL_W-1:0] level_o,
  output logic             flag_z_o,
  output logic             flag_c_o,
  output logic [W-1:0]     acc_o,
  output logic             store_en_o,
  output logic [W-1:0]     store_data_o
);

  pe_op_e op;
  assign op = pe_op_e'(op_i);

  logic op_frz, op_st, exec;
  assign op_frz = is_frz_grp(op);
  assign op_st  = is_store(op);
  assign exec   = issue_i && !frozen_o && !op_frz && !op_st;

  logic [W-1:0] rs, shd;
  logic         wr_en, wr_acc, shw_en, z_we, z_d, c_we, c_d;
  logic [W-1:0] wr_data, shw_data;
  logic         z_q, c_q;

  simd_lane_alu #(.W(W)) i_alu (
    .op_i       (op),
    .acc_i      (acc_o),
    .rs_i       (rs),
    .shd_i      (shd),
    .data_i     (data_i),
    .wr_en_o    (wr_en),
    .wr_acc_o   (wr_acc),
    .wr_data_o  (wr_data),
    .shw_en_o   (shw_en),
    .shw_data_o (shw_data),
    .z_we_o     (z_we),
    .z_d_o      (z_d),
    .c_we_o     (c_we),
    .c_d_o      (c_d)
  );

  simd_lane_regfile #(.W(W), .NREG(NREG), .SEL_W(SEL_W)) i_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .wr_en_i    (exec && wr_en),
    .wr_idx_i   (wr_acc ? '0 : sel_i),
    .wr_data_i  (wr_data),
    .shw_en_i   (exec && shw_en),
    .shw_data_i (shw_data),
    .acc_o      (acc_o),
    .rs_o       (rs),
    .shd_o      (shd)
  );

  // mask codes 20..23 map onto the shared flag test; 24 is unmask
  logic frz_req, unfrz_req, frz_cond;
  assign frz_req   = issue_i && op_frz && (op != OP_UNFRZ);
  assign unfrz_req = issue_i && (op == OP_UNFRZ);
  assign frz_cond  = flag_test(op_i[1:0], z_q, c_q);

  simd_lane_mask #(.LVL_MAX(LVL_MAX), .LVL_W(LVL_W)) i_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frz_req_i   (frz_req),
    .frz_cond_i  (frz_cond),
    .unfrz_req_i (unfrz_req),
    .level_o     (level_o),
    .frozen_o    (frozen_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else if (exec) begin
      if (z_we) z_q <= z_d;
      if (c_we) c_q <= c_d;
    end
  end

  assign flag_z_o = z_q;
  assign flag_c_o = c_q;

  // store codes 25..28: low bits 01,10,11,00 -> test index 0..3
  logic st_cond;
  assign st_cond = flag_test(op_i[1:0] - 2'd1, z_q, c_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_en_o   <= 1'b0;
      store_data_o <= '0;
    end else begin
      store_en_o <= issue_i && op_st && st_cond && !(frozen_o && frz_store_block_i);
      if (issue_i && op_st) store_data_o <= rs;
    end
  end

  p_frozen_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && frozen_o && !op_frz && !op_st)
    |=> ($stable(flag_z_o) && $stable(flag_c_o) && $stable(acc_o)));

  p_store_src_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(issue_i && op_st) |=> !store_en_o);

  p_store_block_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && op_st && frozen_o && frz_store_block_i) |=> !store_en_o);

  p_shl_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !frozen_o && op == OP_SHL) |=> (flag_c_o == $past(acc_o[W-1])));

  p_shr_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !frozen_o && op == OP_SHR) |=> (flag_c_o == $past(acc_o[0])));

endmodule

// File: tb/test_simd_lane_pe.sv
`timescale 1ns/1ps
module test_simd_lane_pe;
  import simd_lane_pkg::*;

  localparam int W = 16;
  localparam int NREG = 8;
  localparam int SEL_W = 3;
  localparam int LVL_MAX = 256;
  localparam int LVL_W = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic issue = 1'b0;
  logic [4:0] op = '0;
  logic [SEL_W-1:0] sel = '0;
  logic [W-1:0] data = '0;
  logic blk = 1'b0;
  logic frozen, z, c, st_en;
  logic [LVL_W-1:0] level;
  logic [W-1:0] acc, st_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  simd_lane_pe #(.W(W), .NREG(NREG), .SEL_W(SEL_W), .LVL_MAX(LVL_MAX), .LVL_W(LVL_W))
  i_simd_lane_pe (
    .clk_i(clk), .rst_ni(rst_ni), .issue_i(issue), .op_i(op), .sel_i(sel),
    .data_i(data), .frz_store_block_i(blk), .frozen_o(frozen), .level_o(level),
    .flag_z_o(z), .flag_c_o(c), .acc_o(acc), .store_en_o(st_en), .store_data_o(st_data)
  );

  typedef struct packed {
    pe_op_e     op;
    logic [2:0] sel;
    logic [15:0] data;
    logic [15:0] acc;
    logic       z;
    logic       c;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{OP_LOAD, 3'd0, 16'h0005, 16'h0005, 1'b0, 1'b0},
    '{OP_LOAD, 3'd1, 16'hFFFF, 16'h0005, 1'b0, 1'b0},
    '{OP_ADD,  3'd1, 16'h0000, 16'h0004, 1'b0, 1'b1},
    '{OP_SUB,  3'd1, 16'h0000, 16'h0005, 1'b0, 1'b1},
    '{OP_LOAD, 3'd2, 16'h0005, 16'h0005, 1'b0, 1'b1},
    '{OP_SUB,  3'd2, 16'h0000, 16'h0000, 1'b1, 1'b0},
    '{OP_OR,   3'd2, 16'h0000, 16'h0005, 1'b0, 1'b0},
    '{OP_AND,  3'd1, 16'h0000, 16'h0005, 1'b0, 1'b0},
    '{OP_XOR,  3'd2, 16'h0000, 16'h0000, 1'b1, 1'b0},
    '{OP_INV,  3'd2, 16'h0000, 16'hFFFA, 1'b0, 1'b0},
    '{OP_SHL,  3'd0, 16'h0000, 16'hFFF4, 1'b0, 1'b1},
    '{OP_SHR,  3'd0, 16'h0000, 16'h7FFA, 1'b0, 1'b0},
    '{OP_MOVA, 3'd2, 16'h0000, 16'h0005, 1'b0, 1'b0},
    '{OP_SETC, 3'd0, 16'h0000, 16'h0005, 1'b0, 1'b1},
    '{OP_XOR,  3'd0, 16'h0000, 16'h0000, 1'b1, 1'b1},
    '{OP_CLRC, 3'd0, 16'h0000, 16'h0000, 1'b1, 1'b0},
    '{OP_CLRZ, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0},
    '{OP_SETZ, 3'd0, 16'h0000, 16'h0000, 1'b1, 1'b0},
    '{OP_SHR,  3'd0, 16'h0000, 16'h0000, 1'b1, 1'b0},
    '{OP_LOAD, 3'd3, 16'h8001, 16'h0000, 1'b1, 1'b0},
    '{OP_MOVA, 3'd3, 16'h0000, 16'h8001, 1'b0, 1'b0},
    '{OP_SHL,  3'd0, 16'h0000, 16'h0002, 1'b0, 1'b1},
    '{OP_SHR,  3'd0, 16'h0000, 16'h0001, 1'b0, 1'b0},
    '{OP_SETZ, 3'd0, 16'h0000, 16'h0001, 1'b1, 1'b0},
    '{OP_RST,  3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0},
    '{OP_SET,  3'd0, 16'h0000, 16'hFFFF, 1'b0, 1'b0},
    '{OP_ADD,  3'd2, 16'h0000, 16'h0004, 1'b0, 1'b1},
    '{OP_MOVA, 3'd1, 16'h0000, 16'hFFFF, 1'b0, 1'b1},
    '{OP_SUB,  3'd1, 16'h0000, 16'h0000, 1'b1, 1'b0},
    '{OP_ADD,  3'd2, 16'h0000, 16'h0005, 1'b0, 1'b0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(pe_op_e o, logic [SEL_W-1:0] s, logic [W-1:0] d);
    @(negedge clk);
    issue = 1'b1; op = o; sel = s; data = d;
    @(negedge clk);
    issue = 1'b0; op = OP_NOP;
  endtask

  function automatic string req_of(pe_op_e o);
    case (o)
      OP_ADD, OP_SUB: return "R2";
      OP_AND, OP_OR, OP_XOR, OP_INV, OP_MOVA: return "R3";
      OP_SHL, OP_SHR: return "R4";
      OP_RST, OP_SET: return "R5";
      OP_SETZ, OP_SETC, OP_CLRZ, OP_CLRC: return "R7";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 acc", 32'(acc), 0);
    chk("R1 z", 32'(z), 0);
    chk("R1 c", 32'(c), 0);
    chk("R1 level", 32'(level), 0);
    chk("R1 frozen", 32'(frozen), 0);
    chk("R1 st_en", 32'(st_en), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].op, VECS[i].sel, VECS[i].data);
      chk({req_of(VECS[i].op), " acc"}, 32'(acc), 32'(VECS[i].acc));
      chk({req_of(VECS[i].op), " z"}, 32'(z), 32'(VECS[i].z));
      chk({req_of(VECS[i].op), " c"}, 32'(c), 32'(VECS[i].c));
    end
    // acc=5, z=0, c=0

    // R6 shadow moves, read back via store data
    run(OP_LOAD, 3'd4, 16'h1234);
    run(OP_MOVTS, 3'd4, 16'h0);
    run(OP_LOAD, 3'd4, 16'h0000);
    run(OP_MOVFS, 3'd4, 16'h0);
    run(OP_STC, 3'd4, 16'h0);
    chk("R6 movts/movfs", 32'(st_data), 32'h1234);
    chk("R12 stc c=0 no req", 32'(st_en), 0);
    run(OP_LOAD, 3'd5, 16'hAAAA);
    run(OP_MOVTS, 3'd5, 16'h0);
    run(OP_LOAD, 3'd5, 16'h5555);
    run(OP_SWAP, 3'd5, 16'h0);
    run(OP_STNC, 3'd5, 16'h0);
    chk("R6 swap reg", 32'(st_data), 32'hAAAA);
    chk("R12 stnc c=0 req", 32'(st_en), 1);
    run(OP_MOVFS, 3'd5, 16'h0);
    run(OP_STNC, 3'd5, 16'h0);
    chk("R6 swap shadow", 32'(st_data), 32'h5555);
    run(OP_MOVR, 3'd6, 16'h0);
    run(OP_SETC, 3'd0, 16'h0);
    run(OP_STC, 3'd6, 16'h0);
    chk("R6 movr", 32'(st_data), 32'h0005);
    chk("R12 stc c=1 req", 32'(st_en), 1);
    run(OP_STNZ, 3'd6, 16'h0);
    chk("R12 stnz z=0 req", 32'(st_en), 1);
    run(OP_STZ, 3'd6, 16'h0);
    chk("R12 stz z=0 no req", 32'(st_en), 0);
    chk("R6 flags untouched", 32'({z, c}), 32'b01);

    // R8 conditional masking at depth 0 (z=0, c=1)
    run(OP_FRZNC, 3'd0, 16'h0);
    chk("R8 frznc c=1", 32'(level), 0);
    run(OP_FRZZ, 3'd0, 16'h0);
    chk("R8 frzz z=0", 32'(level), 0);
    run(OP_FRZC, 3'd0, 16'h0);
    chk("R8 frzc c=1", 32'(level), 1);
    chk("R10 frozen high", 32'(frozen), 1);

    // R13 stores while masked
    blk = 1'b0;
    run(OP_STC, 3'd6, 16'h0);
    chk("R13 masked store allowed", 32'(st_en), 1);
    blk = 1'b1;
    run(OP_STC, 3'd6, 16'h0);
    chk("R13 masked store blocked", 32'(st_en), 0);
    blk = 1'b0;

    // R9 masked lane ignores work, nests unconditionally
    run(OP_LOAD, 3'd0, 16'h7777);
    chk("R9 load ignored", 32'(acc), 32'h0005);
    run(OP_CLRC, 3'd0, 16'h0);
    chk("R9 clrc ignored", 32'(c), 1);
    run(OP_SETZ, 3'd0, 16'h0);
    chk("R9 setz ignored", 32'(z), 0);
    run(OP_MOVR, 3'd6, 16'h0);
    run(OP_STC, 3'd5, 16'h0);
    run(OP_STC, 3'd6, 16'h0);
    chk("R9 movr ignored", 32'(st_data), 32'h0005);
    run(OP_FRZNC, 3'd0, 16'h0);
    chk("R9 nest unconditional", 32'(level), 2);

    // R10 unmask
    run(OP_UNFRZ, 3'd0, 16'h0);
    chk("R10 step down", 32'(level), 1);
    run(OP_UNFRZ, 3'd0, 16'h0);
    chk("R10 to zero", 32'(level), 0);
    chk("R10 frozen low", 32'(frozen), 0);
    run(OP_UNFRZ, 3'd0, 16'h0);
    chk("R10 floor", 32'(level), 0);
    run(OP_FRZNZ, 3'd0, 16'h0);
    chk("R8 frznz z=0", 32'(level), 1);
    run(OP_UNFRZ, 3'd0, 16'h0);

    // R11 saturation
    for (int k = 0; k < LVL_MAX + 4; k++) run(OP_FRZC, 3'd0, 16'h0);
    chk("R11 saturate", 32'(level), LVL_MAX);
    run(OP_UNFRZ, 3'd0, 16'h0);
    chk("R11 below top", 32'(level), LVL_MAX - 1);
    for (int k = 0; k < LVL_MAX - 1; k++) run(OP_UNFRZ, 3'd0, 16'h0);
    chk("R10 unwound", 32'(level), 0);
    run(OP_LOAD, 3'd0, 16'h00AB);
    chk("R9 work resumes", 32'(acc), 32'h00AB);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule